// File: doc/BRIEF.md
# Local Interrupt Selection Unit

This block decides, every cycle, whether a hart should take a local interrupt and which one. It combines the pending and enable vectors into a candidate set. A global enable is chosen for each candidate according to its delegation bit. The lowest-numbered survivor wins. The winning cause, a take strobe and a hypervisor-redirect flag are registered and presented one cycle after the inputs.

When the hart runs a virtualized guest, interrupts that belong to the host are considered first. They are gated by the host's own supervisor enable, and a winner among them raises the redirect flag. Only when none of them survives does the block consider the guest interrupts. It moves each guest bit down by one position, onto the matching supervisor cause, and sends the result through the normal delegation gating.

Top module: `irq_select_top`

## Requirements
- R1: An interrupt index is a candidate only when both its `irq_pend` and `irq_en` bits are 1.
- R2: Machine gating is open when `cur_priv` is below 3, or when `cur_priv` is 3 and `m_ie` is 1.
- R3: Supervisor gating is open when `cur_priv` is 0, or when `cur_priv` is 1 and `s_ie` is 1. The priv encoding is U=0, S=1, M=3, and the value 2 counts as below M and not equal to S.
- R4: A candidate whose `deleg` bit is 0 passes only under machine gating. A candidate whose `deleg` bit is 1 passes only under supervisor gating.
- R5: When several candidates pass, `cause_o` is the lowest passing index.
- R6: When no candidate passes, `take_o`, `to_hyp_o` and `cause_o` are all 0 in the following cycle.
- R7: Bits 2, 6 and 10 are guest bits and are never candidates on their own indices. With `virt_on`=1, each guest candidate is moved to the index one lower (2→1, 6→5, 10→9) and then gated as in R4.
- R8: With `virt_on`=1, non-guest candidates come first. They are gated only by a host enable, which is open when `cur_priv` is 0, or when `cur_priv` is 1 and `hs_s_ie` is 1. If any of them passes, the lowest one wins and `to_hyp_o` is 1. Otherwise the guest set of R7 is used and `to_hyp_o` is 0.
- R9: Outputs are registered. A change on the inputs appears on the outputs after the next rising clock edge. While `rst_n` is 0, all outputs are 0.
- R10: With `virt_on`=0, `to_hyp_o` is always 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_pend | input | NUM_IRQ | Pending interrupt bits |
| irq_en | input | NUM_IRQ | Per-interrupt enable bits |
| deleg | input | NUM_IRQ | Delegation bit per interrupt (1 = supervisor) |
| cur_priv | input | 2 | Current privilege (U=0, S=1, M=3) |
| m_ie | input | 1 | Machine global interrupt enable |
| s_ie | input | 1 | Supervisor global interrupt enable |
| virt_on | input | 1 | Guest execution active |
| hs_s_ie | input | 1 | Host supervisor global enable used in guest mode |
| take_o | output | 1 | An interrupt should be taken |
| cause_o | output | CAUSE_W | Winning interrupt index |
| to_hyp_o | output | 1 | Winner must be handled by the host |

## Verification
The assertions treat `irq_pend`, `irq_en` and `deleg` as fully free. They assume only that every input is a known value at each rising edge and is held stable across that edge. The stimulus meets this by changing inputs only on falling edges. Every privilege value, including the unused code 2, is legal stimulus. The random mix covers all of them, with sparse pending vectors, so that the lowest-index priority and the gate choices produce distinct winners.

// File: rtl/irq_select_pkg.sv
package irq_select_pkg;

    typedef enum logic [1:0] {
        PRIV_USER  = 2'd0,
        PRIV_SUPER = 2'd1,
        PRIV_RSVD  = 2'd2,
        PRIV_MACH  = 2'd3
    } priv_e;

    typedef struct packed {
        logic m_open;
        logic s_open;
        logic hs_open;
    } gate_t;

endpackage

// File: rtl/irq_priv_gate.sv
module irq_priv_gate
    import irq_select_pkg::*;
(
    input  logic [1:0] priv,
    input  logic       m_ie,
    input  logic       s_ie,
    input  logic       hs_s_ie,
    output gate_t      gate
);
    always_comb begin
        gate.m_open  = (priv != PRIV_MACH) || m_ie;
        gate.s_open  = (priv == PRIV_USER) || ((priv == PRIV_SUPER) && s_ie);
        gate.hs_open = (priv == PRIV_USER) || ((priv == PRIV_SUPER) && hs_s_ie);
    end
endmodule

// File: rtl/irq_lsb_pick.sv
module irq_lsb_pick #(
    parameter int WIDTH = 16,
    localparam int IDX_W = (WIDTH > 1) ? $clog2(WIDTH) : 1
) (
    input  logic [WIDTH-1:0] vec,
    output logic             any,
    output logic [IDX_W-1:0] idx
);
    logic [WIDTH:0]   seen;
    logic [WIDTH-1:0] first;

    assign seen[0] = 1'b0;

    for (genvar g = 0; g < WIDTH; g++) begin : g_chain
        assign first[g]  = vec[g] & ~seen[g];
        assign seen[g+1] = seen[g] | vec[g];
    end

    assign any = seen[WIDTH];

    always_comb begin
        idx = '0;
        for (int i = 0; i < WIDTH; i++) begin
            if (first[i]) idx = idx | IDX_W'(i);
        end
    end
endmodule

// File: rtl/irq_cand_split.sv
module irq_cand_split #(
    parameter int NUM_IRQ = 16,
    parameter int GUEST_SW = 2,
    parameter int GUEST_TM = 6,
    parameter int GUEST_EX = 10
) (
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_en,
    output logic [NUM_IRQ-1:0] host_set,
    output logic [NUM_IRQ-1:0] guest_set
);
    localparam logic [NUM_IRQ-1:0] GUEST_MASK =
        (NUM_IRQ'(1) << GUEST_SW) | (NUM_IRQ'(1) << GUEST_TM) | (NUM_IRQ'(1) << GUEST_EX);

    logic [NUM_IRQ-1:0] cand;

    always_comb begin
        cand      = irq_pend & irq_en;
        host_set  = cand & ~GUEST_MASK;
        guest_set = (cand & GUEST_MASK) >> 1;
    end
endmodule

// File: rtl/irq_select_top.sv
module irq_select_top
    import irq_select_pkg::*;
#(
    parameter int NUM_IRQ = 16,
    parameter int GUEST_SW = 2,
    parameter int GUEST_TM = 6,
    parameter int GUEST_EX = 10,
    localparam int CAUSE_W = $clog2(NUM_IRQ)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_IRQ-1:0] irq_pend,
    input  logic [NUM_IRQ-1:0] irq_en,
    input  logic [NUM_IRQ-1:0] deleg,
    input  logic [1:0]         cur_priv,
    input  logic               m_ie,
    input  logic               s_ie,
    input  logic               virt_on,
    input  logic               hs_s_ie,
    output logic               take_o,
    output logic [CAUSE_W-1:0] cause_o,
    output logic               to_hyp_o
);
    typedef struct packed {
        logic               take;
        logic [CAUSE_W-1:0] cause;
        logic               to_hyp;
    } out_t;

    gate_t              gate;
    logic [NUM_IRQ-1:0] host_set;
    logic [NUM_IRQ-1:0] guest_set;
    logic [NUM_IRQ-1:0] hyp_pool;
    logic [NUM_IRQ-1:0] norm_pool;
    logic [NUM_IRQ-1:0] survivors;
    logic               hyp_any;
    logic               surv_any;
    logic [CAUSE_W-1:0] hyp_idx;
    logic [CAUSE_W-1:0] surv_idx;
    out_t               out_d;
    out_t               out_q;

    irq_priv_gate u_gate (
        .priv    (cur_priv),
        .m_ie    (m_ie),
        .s_ie    (s_ie),
        .hs_s_ie (hs_s_ie),
        .gate    (gate)
    );

    irq_cand_split #(
        .NUM_IRQ  (NUM_IRQ),
        .GUEST_SW (GUEST_SW),
        .GUEST_TM (GUEST_TM),
        .GUEST_EX (GUEST_EX)
    ) u_split (
        .irq_pend  (irq_pend),
        .irq_en    (irq_en),
        .host_set  (host_set),
        .guest_set (guest_set)
    );

    always_comb begin
        hyp_pool  = (virt_on && gate.hs_open) ? host_set : '0;
        norm_pool = virt_on ? guest_set : host_set;
        survivors = (norm_pool & ~deleg & {NUM_IRQ{gate.m_open}})
                  | (norm_pool &  deleg & {NUM_IRQ{gate.s_open}});
    end

    irq_lsb_pick #(.WIDTH(NUM_IRQ)) u_pick_hyp (
        .vec (hyp_pool),
        .any (hyp_any),
        .idx (hyp_idx)
    );

    irq_lsb_pick #(.WIDTH(NUM_IRQ)) u_pick_norm (
        .vec (survivors),
        .any (surv_any),
        .idx (surv_idx)
    );

    always_comb begin
        out_d = '0;
        if (hyp_any) begin
            out_d.take   = 1'b1;
            out_d.cause  = hyp_idx;
            out_d.to_hyp = 1'b1;
        end else if (surv_any) begin
            out_d.take   = 1'b1;
            out_d.cause  = surv_idx;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign take_o   = out_q.take;
    assign cause_o  = out_q.cause;
    assign to_hyp_o = out_q.to_hyp;
endmodule

// File: rtl/irq_select_chk.sv
module irq_select_chk #(
    parameter int NUM_IRQ = 16,
    parameter int CAUSE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic [NUM_IRQ-1:0] irq_pend,
    input logic [NUM_IRQ-1:0] irq_en,
    input logic [1:0]         cur_priv,
    input logic               m_ie,
    input logic               virt_on,
    input logic               take_o,
    input logic [CAUSE_W-1:0] cause_o,
    input logic               to_hyp_o
);
    logic [NUM_IRQ-1:0] cand_q;
    logic               virt_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cand_q <= '0;
            virt_q <= 1'b0;
        end else begin
            cand_q <= irq_pend & irq_en;
            virt_q <= virt_on;
        end
    end

    assert_hyp_implies_take_R8: assert property (@(posedge clk) disable iff (!rst_n)
        to_hyp_o |-> take_o);

    assert_idle_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        !take_o |-> (cause_o == '0 && !to_hyp_o));

    assert_no_cand_no_take_R1: assert property (@(posedge clk) disable iff (!rst_n)
        ((irq_pend & irq_en) == '0) |=> !take_o);

    assert_mach_masked_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (cur_priv == 2'd3 && !m_ie) |=> !take_o);

    assert_no_virt_no_hyp_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !virt_on |=> !to_hyp_o);

    assert_cause_was_cand_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && (!virt_q || to_hyp_o)) |-> cand_q[cause_o]);

    assert_guest_shift_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (take_o && virt_q && !to_hyp_o) |-> cand_q[cause_o + 1'b1]);
endmodule

bind irq_select_top irq_select_chk #(
    .NUM_IRQ (NUM_IRQ),
    .CAUSE_W (CAUSE_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .irq_pend (irq_pend),
    .irq_en   (irq_en),
    .cur_priv (cur_priv),
    .m_ie     (m_ie),
    .virt_on  (virt_on),
    .take_o   (take_o),
    .cause_o  (cause_o),
    .to_hyp_o (to_hyp_o)
);

// File: tb/irq_select_top_test.sv
module irq_select_top_test;
    localparam int N  = 16;
    localparam int CW = 4;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [N-1:0]  irq_pend = '0;
    logic [N-1:0]  irq_en = '0;
    logic [N-1:0]  deleg = '0;
    logic [1:0]    cur_priv = 2'd0;
    logic          m_ie = 1'b0;
    logic          s_ie = 1'b0;
    logic          virt_on = 1'b0;
    logic          hs_s_ie = 1'b0;
    logic          take_o;
    logic [CW-1:0] cause_o;
    logic          to_hyp_o;

    int total = 0;
    int bad = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    irq_select_top uut (
        .clk(clk), .rst_n(rst_n), .irq_pend(irq_pend), .irq_en(irq_en),
        .deleg(deleg), .cur_priv(cur_priv), .m_ie(m_ie), .s_ie(s_ie),
        .virt_on(virt_on), .hs_s_ie(hs_s_ie),
        .take_o(take_o), .cause_o(cause_o), .to_hyp_o(to_hyp_o)
    );

    function automatic logic [5:0] expect_out(
        input logic [N-1:0] p, input logic [N-1:0] e, input logic [N-1:0] d,
        input logic [1:0] pr, input logic mi, input logic si,
        input logic vo, input logic hsi);
        logic [N-1:0] c, gm, host, guest, pool;
        logic mo, so, ho;
        c = p & e;
        gm = '0; gm[2] = 1'b1; gm[6] = 1'b1; gm[10] = 1'b1;
        host = c & ~gm;
        guest = (c & gm) >> 1;
        mo = (pr != 2'd3) || mi;
        so = (pr == 2'd0) || (pr == 2'd1 && si);
        ho = (pr == 2'd0) || (pr == 2'd1 && hsi);
        if (vo && ho) begin
            for (int i = 0; i < N; i++)
                if (host[i]) return {1'b1, 4'(i), 1'b1};
        end
        pool = vo ? guest : host;
        for (int i = 0; i < N; i++) begin
            if (pool[i] && ((!d[i] && mo) || (d[i] && so)))
                return {1'b1, 4'(i), 1'b0};
        end
        return 6'b0;
    endfunction

    task automatic check(input string req);
        logic [5:0] exp_v, act;
        exp_v = expect_out(irq_pend, irq_en, deleg, cur_priv, m_ie, s_ie, virt_on, hs_s_ie);
        @(posedge clk);
        @(negedge clk);
        act = {take_o, cause_o, to_hyp_o};
        total++;
        if (act !== exp_v) begin
            bad++;
            $display("FAIL %s: take/cause/hyp actual=%b/%0d/%b expected=%b/%0d/%b",
                     req, act[5], act[4:1], act[0], exp_v[5], exp_v[4:1], exp_v[0]);
        end
    endtask

    task automatic drive(input logic [N-1:0] p, input logic [N-1:0] e,
                         input logic [N-1:0] d, input logic [1:0] pr,
                         input logic mi, input logic si, input logic vo, input logic hsi);
        irq_pend = p; irq_en = e; deleg = d; cur_priv = pr;
        m_ie = mi; s_ie = si; virt_on = vo; hs_s_ie = hsi;
    endtask

    initial begin
        #400000;
        if (!finished) begin
            total++; bad++;
            $display("FAIL watchdog: actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'h5eed_1234));
        // R9: outputs zero under reset even with live candidates
        drive(16'hFFFF, 16'hFFFF, 16'h0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0);
        repeat (3) @(posedge clk);
        @(negedge clk);
        total++;
        if ({take_o, cause_o, to_hyp_o} !== 6'b0) begin
            bad++;
            $display("FAIL R9: reset outputs actual=%b expected=000000", {take_o, cause_o, to_hyp_o});
        end
        rst_n = 1'b1;

        // R1: pending without enable
        drive(16'h0080, 16'h0000, 16'h0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0); check("R1");
        drive(16'h0080, 16'h0080, 16'h0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0); check("R1");
        // R2: machine priv, mie off / on
        drive(16'h0880, 16'hFFFF, 16'h0, 2'd3, 1'b0, 1'b1, 1'b0, 1'b0); check("R2");
        drive(16'h0880, 16'hFFFF, 16'h0, 2'd3, 1'b1, 1'b0, 1'b0, 1'b0); check("R2");
        // R3: supervisor priv, delegated, sie off / on; reserved priv 2
        drive(16'h0020, 16'hFFFF, 16'hFFFF, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0); check("R3");
        drive(16'h0020, 16'hFFFF, 16'hFFFF, 2'd1, 1'b0, 1'b1, 1'b0, 1'b0); check("R3");
        drive(16'h0020, 16'hFFFF, 16'hFFFF, 2'd2, 1'b1, 1'b1, 1'b0, 1'b0); check("R3");
        // R4: delegation picks a gate per bit; bit 3 undelegated passes at S
        drive(16'h0028, 16'hFFFF, 16'h0020, 2'd1, 1'b0, 1'b0, 1'b0, 1'b0); check("R4");
        drive(16'h0028, 16'hFFFF, 16'h0008, 2'd3, 1'b1, 1'b1, 1'b0, 1'b0); check("R4");
        // R5: lowest index wins
        drive(16'h8A02, 16'hFFFF, 16'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0); check("R5");
        drive(16'h8000, 16'hFFFF, 16'h0, 2'd0, 1'b0, 1'b0, 1'b0, 1'b0); check("R5");
        // R6: nothing passes after a take
        drive(16'h0000, 16'hFFFF, 16'h0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0); check("R6");
        // R7: guest bits ignored when not virtualized; shifted when virtualized
        drive(16'h0444, 16'hFFFF, 16'h0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b0); check("R7");
        drive(16'h0440, 16'hFFFF, 16'hFFFF, 2'd0, 1'b1, 1'b1, 1'b1, 1'b0); check("R7");
        // R8: host candidate in guest mode forces host; hs gate closed falls to guest
        drive(16'h0480, 16'hFFFF, 16'hFFFF, 2'd1, 1'b1, 1'b1, 1'b1, 1'b1); check("R8");
        drive(16'h0480, 16'hFFFF, 16'hFFFF, 2'd1, 1'b1, 1'b1, 1'b1, 1'b0); check("R8");
        drive(16'h0480, 16'hFFFF, 16'h0000, 2'd3, 1'b1, 1'b1, 1'b1, 1'b1); check("R8");
        // R10: virt off never flags host
        drive(16'h0002, 16'hFFFF, 16'h0, 2'd0, 1'b1, 1'b1, 1'b0, 1'b1); check("R10");

        for (int k = 0; k < 3000; k++) begin
            logic [N-1:0] p;
            p = N'($urandom) & N'($urandom) & N'($urandom);
            drive(p, N'($urandom), N'($urandom), 2'($urandom), 1'($urandom),
                  1'($urandom), 1'($urandom), 1'($urandom));
            check("R5 random");
        end

        finished = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule